// File: doc/BRIEF.md
# Script Branch Condition Evaluator

This block decides whether a transfer-control instruction of a script engine takes its branch. The engine presents the first word of the instruction together with a one-cycle `start` pulse. The block decodes the condition fields of that word. It then tests the ALU carry flag, the latched bus phase lines or the attention line, and the first received data byte, and it reports the outcome as `taken`, qualified by a one-cycle `done` pulse.

A data compare may ignore any subset of bits through a mask. The phase compare means different things in initiator and target operation. One polarity bit picks between branch-on-true and branch-on-false. When two compares are enabled together, a branch on false needs both to fail, so it is not the inverse of a branch on true. When the instruction asks to wait for a valid phase, evaluation stalls until the bus side strobes a phase that no earlier evaluation has consumed. A carry test mixed with a phase or data compare is an illegal combination. The block flags it, and the carry alone then decides.

Top module: `xcond_eval`

## Requirements
- R1: With bit 16 of the instruction clear, a `start` sampled on a clock edge yields `done` high for exactly the cycle after that edge, with `taken` valid in that same cycle.
- R2: When bit 21 (carry test) is set, `taken` equals the carry input if bit 19 (polarity) is 1, and equals its inverse if bit 19 is 0.
- R3: When bit 21 is set together with bit 18 (data compare) or bit 17 (phase compare), `cond_error` is high during `done`, and `taken` follows the carry rule of R2 only.
- R4: With bit 18 set, the data compare is true when every received-byte bit whose mask bit (bits 15-8) is 0 equals the matching bit of the compare value (bits 7-0). Bits whose mask bit is 1 are ignored.
- R5: In initiator mode (`target_mode` = 0) with bit 17 set, the phase compare is true when `phase_lines` equals bits 26-24.
- R6: In target mode (`target_mode` = 1) with bit 17 set, the phase compare is true exactly when `atn_in` is 1, and `phase_lines` has no effect.
- R7: With both bits 17 and 18 set, polarity 1 branches only when both compares are true, and polarity 0 branches only when both compares are false. A mixed outcome is not taken under either polarity.
- R8: With bits 21, 18 and 17 all clear, the condition counts as true, so `taken` equals the polarity bit.
- R9: With bit 16 set, evaluation waits until a `phase_valid` strobe that no earlier waiting evaluation has consumed. A strobe that arrives before `start` counts, and it is consumed by one waiting evaluation only. Compares use the inputs present on the evaluating edge.
- R10: A `start` that arrives while an evaluation is waiting is ignored. It produces no `done` and does not replace the held instruction.
- R11: `taken` and `cond_error` are 0 in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to evaluate `instr_word` |
| instr_word | input | 32 | First word of the transfer-control instruction |
| target_mode | input | 1 | 1 = target operation, 0 = initiator operation |
| carry_in | input | 1 | ALU carry flag |
| phase_lines | input | 3 | Latched bus phase lines (message, control/data, in/out) |
| atn_in | input | 1 | Bus attention line, active high |
| first_byte | input | 8 | First byte received from the bus |
| phase_valid | input | 1 | Strobe marking a newly latched phase as valid |
| done | output | 1 | One-cycle pulse: result valid |
| taken | output | 1 | Branch taken, valid with `done` |
| cond_error | output | 1 | Illegal carry-plus-compare combination, valid with `done` |

## Verification
The hardest case to reach is the phase-freshness bookkeeping. A strobe that arrives before a waiting request must satisfy it once and then be spent, so that a second waiting request stalls even though the phase lines still hold a matching value. The stimulus strobes a phase with no request pending, issues two waiting requests back to back, and then tries to slip a contradictory `start` in while the second one stalls. After that it checks that exactly one result appears, and that the result belongs to the held instruction once a new strobe arrives.

// File: rtl/xcond_pkg.sv
package xcond_pkg;

    localparam int INSTR_W  = 32;
    localparam int PHASE_W  = 3;
    localparam int DATA_W   = 8;

    localparam int POS_PHASE = 24;
    localparam int POS_CARRY = 21;
    localparam int POS_POL   = 19;
    localparam int POS_DATA  = 18;
    localparam int POS_PHCMP = 17;
    localparam int POS_WAIT  = 16;
    localparam int POS_MASK  = 8;
    localparam int POS_VALUE = 0;

    typedef struct packed {
        logic                carry_en;
        logic                polarity;
        logic                data_en;
        logic                phase_en;
        logic                wait_phase;
        logic [PHASE_W-1:0]  exp_phase;
        logic [DATA_W-1:0]   mask;
        logic [DATA_W-1:0]   value;
    } cond_fields_t;

    typedef struct packed {
        logic taken;
        logic error;
    } cond_result_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } eval_state_t;

    function automatic cond_fields_t split_fields(input logic [INSTR_W-1:0] w);
        cond_fields_t f;
        f.carry_en   = w[POS_CARRY];
        f.polarity   = w[POS_POL];
        f.data_en    = w[POS_DATA];
        f.phase_en   = w[POS_PHCMP];
        f.wait_phase = w[POS_WAIT];
        f.exp_phase  = w[POS_PHASE +: PHASE_W];
        f.mask       = w[POS_MASK  +: DATA_W];
        f.value      = w[POS_VALUE +: DATA_W];
        return f;
    endfunction

    function automatic logic apply_polarity(input logic pol, input logic cond);
        return pol ? cond : ~cond;
    endfunction

endpackage

// File: rtl/xcond_decode.sv
module xcond_decode
    import xcond_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output cond_fields_t       fields
);
    logic unused_bits;
    assign unused_bits = ^{word[31:27], word[23:22], word[20]};

    always_comb begin
        fields = split_fields(word);
    end
endmodule

// File: rtl/xcond_compare.sv
module xcond_compare
    import xcond_pkg::*;
(
    input  cond_fields_t       fields,
    input  logic               target_mode,
    input  logic               carry_in,
    input  logic [PHASE_W-1:0] phase_lines,
    input  logic               atn_in,
    input  logic [DATA_W-1:0]  first_byte,
    output cond_result_t       result
);
    logic [DATA_W-1:0] bit_ok;
    logic data_hit;
    logic phase_hit;
    logic any_cmp;
    logic all_true;
    logic all_false;

    // masked bitwise equality, one cell per data bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bit_ok[i] = fields.mask[i] | ~(first_byte[i] ^ fields.value[i]);
    end

    assign data_hit  = &bit_ok;
    assign phase_hit = target_mode ? atn_in : (phase_lines == fields.exp_phase);

    assign any_cmp   = fields.data_en | fields.phase_en;
    assign all_true  = (~fields.data_en | data_hit)  & (~fields.phase_en | phase_hit);
    assign all_false = (~fields.data_en | ~data_hit) & (~fields.phase_en | ~phase_hit);

    always_comb begin
        result = '0;
        if (fields.carry_en) begin
            result.taken = apply_polarity(fields.polarity, carry_in);
            result.error = any_cmp;
        end else if (!any_cmp) begin
            result.taken = fields.polarity;
        end else begin
            result.taken = fields.polarity ? all_true : all_false;
        end
    end
endmodule

// File: rtl/xcond_phase_track.sv
module xcond_phase_track (
    input  logic clk,
    input  logic rst,
    input  logic phase_valid,
    input  logic consume,
    output logic fresh_now,
    output logic fresh_q
);
    assign fresh_now = fresh_q | phase_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= 1'b0;
        end else if (consume) begin
            fresh_q <= 1'b0;
        end else if (phase_valid) begin
            fresh_q <= 1'b1;
        end
    end
endmodule

// File: rtl/xcond_eval.sv
module xcond_eval
    import xcond_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [31:0]        instr_word,
    input  logic               target_mode,
    input  logic               carry_in,
    input  logic [2:0]         phase_lines,
    input  logic               atn_in,
    input  logic [7:0]         first_byte,
    input  logic               phase_valid,
    output logic               done,
    output logic               taken,
    output logic               cond_error
);
    eval_state_t   state_q;
    logic [INSTR_W-1:0] held_q;
    logic [INSTR_W-1:0] active_word;
    cond_fields_t  fields;
    cond_result_t  res;
    cond_result_t  res_q;
    logic          done_q;
    logic          fresh_now;
    logic          fresh_q;
    logic          accept;
    logic          evaluate;
    logic          consume;
    logic          busy;

    assign busy        = (state_q == ST_WAIT);
    assign accept      = start && !busy;
    assign active_word = busy ? held_q : instr_word;

    xcond_decode u_dec (
        .word   (active_word),
        .fields (fields)
    );

    xcond_compare u_cmp (
        .fields      (fields),
        .target_mode (target_mode),
        .carry_in    (carry_in),
        .phase_lines (phase_lines),
        .atn_in      (atn_in),
        .first_byte  (first_byte),
        .result      (res)
    );

    assign evaluate = (accept || busy) && (!fields.wait_phase || fresh_now);
    assign consume  = evaluate && fields.wait_phase;

    xcond_phase_track u_trk (
        .clk         (clk),
        .rst         (rst),
        .phase_valid (phase_valid),
        .consume     (consume),
        .fresh_now   (fresh_now),
        .fresh_q     (fresh_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= evaluate;
            res_q  <= evaluate ? res : '0;
            if (evaluate) begin
                state_q <= ST_IDLE;
            end else if (accept) begin
                state_q <= ST_WAIT;
                held_q  <= instr_word;
            end
        end
    end

    assign done       = done_q;
    assign taken      = res_q.taken;
    assign cond_error = res_q.error;
endmodule

// File: rtl/xcond_eval_chk.sv
module xcond_eval_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] instr_word,
    input logic        carry_in,
    input logic        phase_valid,
    input logic        done,
    input logic        taken,
    input logic        cond_error,
    input logic        busy,
    input logic        fresh_q
);
    logic unused_chk;
    assign unused_chk = ^{instr_word[31:22], instr_word[20], instr_word[15:0]};

    assert_quiet_outputs_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!taken && !cond_error));

    assert_immediate_done_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !instr_word[16]) |=> done);

    assert_carry_polarity_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && instr_word[21] && !instr_word[16])
        |=> (taken == ($past(instr_word[19]) ~^ $past(carry_in))));

    assert_illegal_mix_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && instr_word[21] && !instr_word[16] && (instr_word[18] || instr_word[17]))
        |=> cond_error);

    assert_unconditional_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !instr_word[21] && !instr_word[18] && !instr_word[17]
         && !instr_word[16] && instr_word[19]) |=> (done && taken));

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !fresh_q && !phase_valid) |=> !done);

    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !fresh_q && !phase_valid) |=> busy);
endmodule

bind xcond_eval xcond_eval_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .instr_word  (instr_word),
    .carry_in    (carry_in),
    .phase_valid (phase_valid),
    .done        (done),
    .taken       (taken),
    .cond_error  (cond_error),
    .busy        (busy),
    .fresh_q     (fresh_q)
);

// File: tb/sim_xcond_eval.sv
`timescale 1ns/1ps
module sim_xcond_eval;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr_word = '0;
    logic        target_mode = 1'b0;
    logic        carry_in = 1'b0;
    logic [2:0]  phase_lines = '0;
    logic        atn_in = 1'b0;
    logic [7:0]  first_byte = '0;
    logic        phase_valid = 1'b0;
    logic        done, taken, cond_error;

    int checks = 0;
    int errors = 0;
    int issued = 0;
    int seen   = 0;
    int quiet_bad = 0;
    bit finished = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    xcond_eval u0 (
        .clk(clk), .rst(rst), .start(start), .instr_word(instr_word),
        .target_mode(target_mode), .carry_in(carry_in), .phase_lines(phase_lines),
        .atn_in(atn_in), .first_byte(first_byte), .phase_valid(phase_valid),
        .done(done), .taken(taken), .cond_error(cond_error)
    );

    function automatic logic [31:0] mk(input logic pol, input logic c, input logic d,
                                       input logic p, input logic w, input logic [2:0] ph,
                                       input logic [7:0] mask, input logic [7:0] val);
        return {2'b10, 3'b000, ph, 1'b0, 1'b0, c, 1'b0, pol, d, p, w, mask, val};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pop expected results as done pulses appear
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R10 unexpected done", 1, 0);
                end else begin
                    automatic logic [1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check({taken, cond_error} == e, t, {taken, cond_error}, e);
                end
            end else if (taken || cond_error) begin
                quiet_bad++;
            end
        end
    end

    task automatic issue(input logic [31:0] w, input logic tgt, input logic cy,
                         input logic [2:0] ph, input logic atn, input logic [7:0] fb,
                         input logic exp_t, input logic exp_e, input string tag);
        @(negedge clk);
        instr_word = w; target_mode = tgt; carry_in = cy;
        phase_lines = ph; atn_in = atn; first_byte = fb;
        start = 1'b1;
        exp_q.push_back({exp_t, exp_e});
        tag_q.push_back(tag);
        issued++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic poke_start(input logic [31:0] w);
        @(negedge clk);
        instr_word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_phase();
        @(negedge clk);
        phase_valid = 1'b1;
        @(negedge clk);
        phase_valid = 1'b0;
    endtask

    task automatic expect_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(done == 1'b0, tag, done, 0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({done, taken, cond_error} == 3'b000, "R11 reset", {done, taken, cond_error}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R8 unconditional
        issue(mk(1,0,0,0,0,3'd0,8'h00,8'h00), 0,0,3'd0,0,8'h00, 1,0, "R8 pol1");
        check(done == 1'b1, "R1 done timing", done, 1);
        issue(mk(0,0,0,0,0,3'd0,8'h00,8'h00), 0,0,3'd0,0,8'h00, 0,0, "R8 pol0");
        // R2 carry
        issue(mk(1,1,0,0,0,3'd0,8'h00,8'h00), 0,1,3'd0,0,8'h00, 1,0, "R2 true carry1");
        issue(mk(1,1,0,0,0,3'd0,8'h00,8'h00), 0,0,3'd0,0,8'h00, 0,0, "R2 true carry0");
        issue(mk(0,1,0,0,0,3'd0,8'h00,8'h00), 0,0,3'd0,0,8'h00, 1,0, "R2 false carry0");
        // R3 illegal mix
        issue(mk(1,1,1,0,0,3'd0,8'h00,8'h33), 0,1,3'd0,0,8'h00, 1,1, "R3 carry+data");
        issue(mk(0,1,0,1,0,3'd5,8'h00,8'h00), 0,1,3'd5,0,8'h00, 0,1, "R3 carry+phase");
        // R4 masked data
        issue(mk(1,0,1,0,0,3'd0,8'h7F,8'h80), 0,0,3'd0,0,8'h85, 1,0, "R4 msb set");
        issue(mk(1,0,1,0,0,3'd0,8'h7F,8'h80), 0,0,3'd0,0,8'h05, 0,0, "R4 msb clear");
        issue(mk(1,0,1,0,0,3'd0,8'h00,8'h5A), 0,0,3'd0,0,8'h5A, 1,0, "R4 exact");
        issue(mk(1,0,1,0,0,3'd0,8'h00,8'h5A), 0,0,3'd0,0,8'h5B, 0,0, "R4 lsb diff");
        issue(mk(0,0,1,0,0,3'd0,8'h00,8'h5A), 0,0,3'd0,0,8'h5B, 1,0, "R4 false pol");
        // R5 initiator phase
        issue(mk(1,0,0,1,0,3'd6,8'h00,8'h00), 0,0,3'd6,0,8'h00, 1,0, "R5 match");
        issue(mk(1,0,0,1,0,3'd6,8'h00,8'h00), 0,0,3'd2,0,8'h00, 0,0, "R5 mismatch");
        issue(mk(0,0,0,1,0,3'd6,8'h00,8'h00), 0,0,3'd2,0,8'h00, 1,0, "R5 false pol");
        // R6 target attention
        issue(mk(1,0,0,1,0,3'd0,8'h00,8'h00), 1,0,3'd0,0,8'h00, 0,0, "R6 atn low");
        issue(mk(1,0,0,1,0,3'd0,8'h00,8'h00), 1,0,3'd7,1,8'h00, 1,0, "R6 atn high");
        // R7 combined
        issue(mk(1,0,1,1,0,3'd3,8'h00,8'h11), 0,0,3'd3,0,8'h11, 1,0, "R7 both true");
        issue(mk(1,0,1,1,0,3'd3,8'h00,8'h11), 0,0,3'd3,0,8'h12, 0,0, "R7 mixed true pol");
        issue(mk(0,0,1,1,0,3'd3,8'h00,8'h11), 0,0,3'd3,0,8'h12, 0,0, "R7 mixed false pol");
        issue(mk(0,0,1,1,0,3'd3,8'h00,8'h11), 0,0,3'd4,0,8'h12, 1,0, "R7 both false");
        @(negedge clk);

        // R9 stall until fresh strobe
        issue(mk(1,0,0,1,1,3'd1,8'h00,8'h00), 0,0,3'd2,0,8'h00, 1,0, "R9 after strobe");
        expect_quiet(4, "R9 stall");
        phase_lines = 3'd1;
        pulse_phase();
        @(negedge clk);
        // R9 strobe before request
        phase_lines = 3'd4;
        pulse_phase();
        @(negedge clk);
        issue(mk(1,0,0,1,1,3'd4,8'h00,8'h00), 0,0,3'd4,0,8'h00, 1,0, "R9 early strobe");
        // R9 strobe already consumed -> stall; R10 start ignored
        issue(mk(1,0,0,1,1,3'd4,8'h00,8'h00), 0,0,3'd4,0,8'h00, 1,0, "R10 held instr");
        expect_quiet(3, "R9 consumed strobe");
        poke_start(mk(0,0,0,0,0,3'd0,8'h00,8'h00));
        expect_quiet(3, "R10 ignored start");
        pulse_phase();
        repeat (3) @(negedge clk);

        check(seen == issued, "R10 done count", seen, issued);
        check(exp_q.size() == 0, "R1 pending results", exp_q.size(), 0);
        check(quiet_bad == 0, "R11 quiet outputs", quiet_bad, 0);
        finish_run();
    end
endmodule